// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is a two-wire serial bus target that lets a bus host read and write a bank of byte-wide registers. It samples the clock and data lines with a fast system clock. Both lines pass through a synchronizer and a glitch filter before the block looks for edges, start conditions and stop conditions. The block answers to one fixed 7-bit device address and drives the data line through an open-drain enable. It reaches the registers through a plain write port and a read port. The read port has a one-cycle latency, so a block RAM can sit behind it.

A host writes by sending the device address with the direction bit clear, then a byte that sets an internal register pointer, then any number of data bytes. A host reads by setting the pointer in the same way, then issuing a repeated start and the device address with the direction bit set. The target then returns bytes from the pointer onward for as long as the host acknowledges them. The host ends the read with a not-acknowledge. The pointer moves forward after every byte, so a burst touches consecutive registers.

Top module: `i2c_regbank_target`

## Requirements
- R1: The target sees a start when SDA falls while SCL is high, and a stop when SDA rises while SCL is high. A start always begins a new address byte, including a start in the middle of a transfer (repeated start). A stop returns the target to idle. After either, sda_oe is 0.
- R2: The first byte after a start is the device address, sent MSB first, followed by a direction bit (0 = write, 1 = read). When the address equals DEV_ADDR, the target pulls SDA low through the whole 9th SCL high period.
- R3: On an address mismatch the target leaves SDA released for the 9th clock and for every later clock. It makes no register write until the next start.
- R4: In a write transfer, the byte after the address is the register pointer and each byte after that is written. Each write is a one-cycle reg_we pulse with reg_waddr equal to the pointer and reg_wdata equal to the byte. Every byte is acknowledged.
- R5: In a read transfer (address with direction bit 1), the target drives the register byte at the pointer, MSB first. A 0 bit is sent by setting sda_oe to 1 and a 1 bit by leaving it at 0.
- R6: When the host acknowledges a read byte, the next byte comes from the next register. After a host not-acknowledge, the target releases SDA and drives nothing until the next start.
- R7: The pointer changes only on a pointer byte and on data bytes. It keeps its value across a repeated start and across a stop. It steps by one after every data byte read or written, and wraps modulo 2^AW.
- R8: A pulse shorter than FILT_LEN system clocks on SCL or SDA has no effect on the transfer.
- R9: Each read request is a one-cycle reg_re pulse with the address on reg_raddr. The byte is taken from reg_rdata one cycle later. reg_re and reg_we are never high in the same cycle.
- R10: After reset, sda_oe, reg_we and reg_re are 0 and the pointer is 0.
- R11: sda_oe changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_we | output | 1 | Register write strobe, one cycle |
| reg_waddr | output | AW | Register write address |
| reg_wdata | output | 8 | Register write data |
| reg_re | output | 1 | Register read strobe, one cycle |
| reg_raddr | output | AW | Register read address |
| reg_rdata | input | 8 | Read data, valid the cycle after reg_re |

## Verification
The bench runs burst writes and burst reads across the top of the pointer range. A design that stops at the last register, or does not wrap, returns the wrong bytes there. One test sets the pointer in one transfer and reads it in a later one; a design that clears the pointer on stop or on a repeated start reads register 0. Another test sends a wrong address followed by data bytes; a target that acknowledges them, or writes them, changes a register that is read back afterwards. One-clock spikes on SCL during the low phase and on SDA during the high phase are injected. Without the filter these add a bit or cause a false start or stop and corrupt the bytes written. After the host not-acknowledges a read, the bench keeps clocking and expects all ones, which catches a target that keeps driving SDA.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_deglitch.sv
module i2c_tgt_deglitch #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          sync1, sync2;
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
      dout  <= 1'b1;
      run   <= '0;
    end else begin
      sync1 <= din;
      sync2 <= sync1;
      if (sync2 == dout) begin
        run <= '0;
      end else if (run == CW'(FILT_LEN - 1)) begin
        dout <= sync2;
        run  <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_events.sv
module i2c_tgt_events (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter int         AW       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [AW-1:0]     reg_waddr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_re,
  output logic [AW-1:0]     reg_raddr,
  input  logic [BYTE_W-1:0] reg_rdata
);
  tgt_state_t        state;
  logic [3:0]        nbits;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [AW-1:0]     ptr;
  logic              load_q;
  logic              host_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      nbits     <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ptr       <= '0;
      load_q    <= 1'b0;
      host_ack  <= 1'b0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_wdata <= '0;
      reg_re    <= 1'b0;
      reg_raddr <= '0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      load_q <= reg_re;
      if (load_q) tx_sh <= reg_rdata;

      if (start_det) begin
        state  <= ST_ADDR;
        nbits  <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_WR: begin
            if (scl_rise) begin
              rx_sh <= {rx_sh[BYTE_W-2:0], sda};
              nbits <= nbits + 1'b1;
            end else if (scl_fall && nbits == 4'd8) begin
              nbits <= '0;
              if (state == ST_ADDR) begin
                if (rx_sh[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  state  <= ST_ADDR_ACK;
                  if (rx_sh[0]) begin
                    reg_re    <= 1'b1;
                    reg_raddr <= ptr;
                  end
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_PTR) begin
                ptr    <= rx_sh[AW-1:0];
                sda_oe <= 1'b1;
                state  <= ST_PTR_ACK;
              end else begin
                reg_we    <= 1'b1;
                reg_waddr <= ptr;
                reg_wdata <= rx_sh;
                ptr       <= ptr + 1'b1;
                sda_oe    <= 1'b1;
                state     <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              nbits <= '0;
              if (rx_sh[0]) begin
                sda_oe <= ~tx_sh[7];
                state  <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK, ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              nbits  <= '0;
              state  <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (nbits == 4'd7) begin
                sda_oe    <= 1'b0;
                nbits     <= '0;
                ptr       <= ptr + 1'b1;
                reg_re    <= 1'b1;
                reg_raddr <= ptr + 1'b1;
                state     <= ST_RD_ACK;
              end else begin
                sda_oe <= ~tx_sh[6];
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                nbits  <= nbits + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              host_ack <= ~sda;
            end else if (scl_fall) begin
              if (host_ack) begin
                sda_oe <= ~tx_sh[7];
                nbits  <= '0;
                state  <= ST_RD;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter int         AW       = 8,
  parameter int         FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              reg_we,
  output logic [AW-1:0]     reg_waddr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_re,
  output logic [AW-1:0]     reg_raddr,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw;
  logic [NLINES-1:0] line_flt;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2c_tgt_deglitch #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk (clk),
      .rst (rst),
      .din (line_raw[g]),
      .dout(line_flt[g])
    );
  end

  assign scl_f = line_flt[0];
  assign sda_f = line_flt[1];

  i2c_tgt_events u_evt (
    .clk      (clk),
    .rst      (rst),
    .scl      (scl_f),
    .sda      (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .sda      (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata),
    .reg_re   (reg_re),
    .reg_raddr(reg_raddr),
    .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker (
  input logic clk,
  input logic rst,
  input logic scl_f,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe,
  input logic reg_we,
  input logic reg_re
);
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_f));

  p_release_start_r1: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);

  p_release_stop_r1: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  p_we_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  p_re_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    reg_re |=> !reg_re);

  p_we_re_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_re));
endmodule

bind i2c_regbank_target i2c_tgt_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_f    (scl_f),
  .start_det(start_det),
  .stop_det (stop_det),
  .sda_oe   (sda_oe),
  .reg_we   (reg_we),
  .reg_re   (reg_re)
);

// File: tb/sim_i2c_regbank_target.sv
`timescale 1ns/1ps
module sim_i2c_regbank_target;
  localparam logic [6:0] TGT = 7'h48;
  localparam int Q = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_bus;
  logic sda_oe, reg_we, reg_re;
  logic [7:0] reg_waddr, reg_raddr, reg_wdata;
  logic [7:0] reg_rdata;
  logic [7:0] mem [256];

  int total = 0;
  int bad = 0;
  int we_cnt = 0;
  int oe_cnt = 0;
  int viol = 0;
  logic prev_oe = 1'b0;
  logic prev_scl = 1'b1;

  always #4 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  i2c_regbank_target #(.DEV_ADDR(TGT), .AW(8), .FILT_LEN(4)) u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_raddr(reg_raddr),
    .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      reg_rdata <= 8'h00;
    end else begin
      if (reg_we) mem[reg_waddr] <= reg_wdata;
      if (reg_re) reg_rdata <= mem[reg_raddr];
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (reg_we) we_cnt++;
      if (sda_oe) oe_cnt++;
      if (sda_oe != prev_oe && m_scl && prev_scl) viol++;
    end
    prev_oe  <= sda_oe;
    prev_scl <= m_scl;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic m_start();
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q);
    m_sda = 1'b0; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; w(Q); m_scl = 1'b1; w(Q);
    m_sda = 1'b1; w(2 * Q);
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    m_sda = b;
    if (glitch) begin
      w(5); m_scl = 1'b1; w(1); m_scl = 1'b0; w(Q - 6);
    end else begin
      w(Q);
    end
    m_scl = 1'b1;
    if (glitch && b) begin
      w(Q); m_sda = 1'b0; w(1); m_sda = 1'b1; w(Q - 1);
    end else begin
      w(2 * Q);
    end
    m_scl = 1'b0; w(Q);
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; w(Q);
    m_scl = 1'b1; w(Q);
    b = sda_bus; w(Q);
    m_scl = 1'b0; w(Q);
  endtask

  task automatic write_byte(input logic [7:0] d, input bit glitch, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i], glitch);
    recv_bit(a);
    acked = !a;
  endtask

  task automatic read_byte(output logic [7:0] d, input bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(!ack, 1'b0);
  endtask

  task automatic set_ptr(input logic [7:0] p, input string tag);
    bit a;
    m_start();
    write_byte({TGT, 1'b0}, 1'b0, a);
    chk(a, {tag, " addr ack"}, a, 1);
    write_byte(p, 1'b0, a);
    chk(a, {tag, " ptr ack"}, a, 1);
  endtask

  task automatic read_from(input logic [7:0] p, input int n, input logic [7:0] e0,
                           input logic [7:0] e1, input logic [7:0] e2, input string tag);
    bit a;
    logic [7:0] d;
    logic [7:0] exp [3];
    exp[0] = e0; exp[1] = e1; exp[2] = e2;
    set_ptr(p, tag);
    m_start();
    write_byte({TGT, 1'b1}, 1'b0, a);
    chk(a, {tag, " raddr ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      read_byte(d, i != n - 1);
      chk(d == exp[i], tag, d, exp[i]);
    end
    m_stop();
  endtask

  task automatic t_reset();
    chk(!sda_oe && !reg_we && !reg_re, "R10 outputs idle", {sda_oe, reg_we, reg_re}, 0);
  endtask

  task automatic t_write_burst();
    bit a;
    set_ptr(8'h10, "R2/R4");
    write_byte(8'hA5, 1'b0, a); chk(a, "R4 data ack", a, 1);
    write_byte(8'h3C, 1'b0, a); chk(a, "R4 data ack", a, 1);
    write_byte(8'hFF, 1'b0, a); chk(a, "R4 data ack", a, 1);
    m_stop();
    w(4);
    chk(mem[8'h10] == 8'hA5, "R4 mem10", mem[8'h10], 8'hA5);
    chk(mem[8'h11] == 8'h3C, "R7 mem11", mem[8'h11], 8'h3C);
    chk(mem[8'h12] == 8'hFF, "R7 mem12", mem[8'h12], 8'hFF);
  endtask

  task automatic t_read_single_nack();
    bit a;
    logic [7:0] d;
    set_ptr(8'h11, "R5");
    m_start();
    write_byte({TGT, 1'b1}, 1'b0, a);
    chk(a, "R2 read addr ack", a, 1);
    read_byte(d, 1'b0);
    chk(d == 8'h3C, "R5/R9 single read", d, 8'h3C);
    chk(!sda_oe, "R6 released after nack", sda_oe, 0);
    read_byte(d, 1'b0);
    chk(d == 8'hFF, "R6 no drive after nack", d, 8'hFF);
    m_stop();
  endtask

  task automatic t_read_burst();
    read_from(8'h10, 3, 8'hA5, 8'h3C, 8'hFF, "R6 burst read");
  endtask

  task automatic t_ptr_persist();
    bit a;
    logic [7:0] d;
    set_ptr(8'h20, "R7 persist");
    m_stop();
    m_start();
    write_byte({TGT, 1'b1}, 1'b0, a);
    chk(a, "R7 addr ack", a, 1);
    read_byte(d, 1'b1);
    chk(d == 8'h7A, "R7 ptr kept over stop", d, 8'h7A);
    read_byte(d, 1'b0);
    chk(d == 8'h7B, "R7 ptr step", d, 8'h7B);
    m_stop();
  endtask

  task automatic t_wrap();
    bit a;
    set_ptr(8'hFF, "R7 wrap");
    write_byte(8'h81, 1'b0, a);
    write_byte(8'h82, 1'b0, a);
    m_stop();
    w(4);
    chk(mem[8'hFF] == 8'h81, "R7 memFF", mem[8'hFF], 8'h81);
    chk(mem[8'h00] == 8'h82, "R7 wrap mem00", mem[8'h00], 8'h82);
    read_from(8'hFF, 2, 8'h81, 8'h82, 8'h00, "R7 read wrap");
  endtask

  task automatic t_mismatch();
    bit a;
    int we0, oe0;
    we0 = we_cnt; oe0 = oe_cnt;
    m_start();
    write_byte({7'h2A, 1'b0}, 1'b0, a);
    chk(!a, "R3 no ack on mismatch", a, 0);
    write_byte(8'h30, 1'b0, a);
    write_byte(8'h99, 1'b0, a);
    m_stop();
    w(4);
    chk(we_cnt == we0, "R3 no writes", we_cnt - we0, 0);
    chk(oe_cnt == oe0, "R3 sda never driven", oe_cnt - oe0, 0);
    read_from(8'h30, 1, 8'h6A, 8'h00, 8'h00, "R3 reg unchanged");
  endtask

  task automatic t_restart_write();
    bit a;
    set_ptr(8'h40, "R1");
    write_byte(8'h11, 1'b0, a);
    m_start();
    write_byte({TGT, 1'b0}, 1'b0, a);
    chk(a, "R1 restart parsed as address", a, 1);
    write_byte(8'h41, 1'b0, a);
    write_byte(8'h22, 1'b0, a);
    m_stop();
    read_from(8'h40, 2, 8'h11, 8'h22, 8'h00, "R1 restart write");
  endtask

  task automatic t_glitch();
    bit a;
    m_start();
    write_byte({TGT, 1'b0}, 1'b1, a);
    chk(a, "R8 glitched addr ack", a, 1);
    write_byte(8'h50, 1'b1, a);
    write_byte(8'hC3, 1'b1, a);
    write_byte(8'h5E, 1'b1, a);
    m_stop();
    read_from(8'h50, 2, 8'hC3, 8'h5E, 8'h00, "R8 glitch filtered");
  endtask

  initial begin
    w(6);
    rst = 1'b0;
    w(3);
    t_reset();
    t_write_burst();
    t_read_single_nack();
    t_read_burst();
    t_ptr_persist();
    t_wrap();
    t_mismatch();
    t_restart_write();
    t_glitch();
    chk(viol == 0, "R11 sda_oe steady while scl high", viol, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule